// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-driven master for the two-wire Ethernet PHY management bus. Software sets up a clock divider, an output hold delay and a frame mode (Clause 22 or Clause 45) in a configuration register. It then starts a frame by writing one of three registers. The block generates MDC from the system clock. It drives MDIO through a split output, output-enable and input, and shifts each frame out MSB first.

The register that is written picks the frame type:
- A data-register write sends a write frame.
- A control-register write with the read-request bit set sends a read frame. On a read the master releases the line for the turnaround and captures sixteen bits from the PHY.
- In Clause 45 mode, an address-register write sends an address frame.

While a frame runs, busy is visible in the configuration register. For write and read frames it is also visible in the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and the MDIO output enable is low.
- R2: MDC is low whenever no frame runs. While a frame runs it has period 2×(div+1) system clocks. The first rising edge is registered div+1 clocks after the launching write edge. div is config bits [7:0].
- R3: Every frame is 64 MDC bits, MSB first: 32 ones, 2 start bits, 2 opcode bits, 5 PHY bits, 5 register bits, 2 turnaround bits and 16 data bits. A driven turnaround is 10. In Clause 22 mode the start is 01 and the opcode is 01 for write and 10 for read.
- R4: In Clause 45 mode (config bit 12 set) the start is 00. The opcode is 00 for address, 01 for write and 11 for read. The port address comes from control bits [9:5] and the device address from control bits [4:0].
- R5: Register words are selected by addr[3:2]: 0 configuration, 1 control, 2 data, 3 address. A data write sends a write frame carrying wdata[15:0]. A control write with bit 15 set sends a read frame. An address write sends an address frame carrying wdata[15:0] only in Clause 45 mode. Control writes without bit 15, configuration writes and Clause 22 address writes start nothing.
- R6: A new MDIO bit appears h system clocks after the MDC falling edge, where h is config bits [10:8] clamped to div. MDIO never changes while MDC is high.
- R7: On a read frame the output enable is low for the last 18 bit times. The 16 data bits are sampled on MDC rising edges and appear in data bits [15:0] when the frame ends.
- R8: Config bit 30 is set when the second turnaround bit of a read is sampled high. It stays set until the next read frame is launched.
- R9: Config bit 31 is set from the launching edge until the frame ends, 128×(div+1) clocks later. Data bit 31 is set over the same span, but only for write and read frames.
- R10: Any register write while a frame runs is ignored. It neither starts a frame nor changes any field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the register at addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench goes after the hold delay when it is zero, when it is non-zero and when it exceeds the divider. A design that ignores the clamp lets MDIO move while MDC is high, and a design that counts one clock off shifts every bit edge against the model. It launches frames through every register, including a Clause 22 address write that must start nothing and writes made during a frame that must be dropped; a wrong decode shows up as an unexpected busy or as a data field overwritten in flight. On reads it drives a bad turnaround and checks that the error flag survives a later write frame and clears only on the next read. A design that samples one edge early or late returns data shifted by one bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DWORD_W   = 16;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_ADDR = 2'd3;

  localparam int CFG_HOLD_LSB = 8;
  localparam int CFG_C45_BIT  = 12;
  localparam int CFG_ERR_BIT  = 30;
  localparam int BUSY_BIT     = 31;
  localparam int CTRL_PHY_LSB = 5;
  localparam int CTRL_RD_BIT  = 15;

  typedef enum logic [1:0] {K_ADDR, K_WRITE, K_READ} kind_e;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic c45, input kind_e kind, input logic [4:0] phy,
    input logic [4:0] rg, input logic [DWORD_W-1:0] data);
    logic [1:0] st;
    logic [1:0] op;
    st = c45 ? 2'b00 : 2'b01;
    if (c45) begin
      case (kind)
        K_ADDR:  op = 2'b00;
        K_READ:  op = 2'b11;
        default: op = 2'b01;
      endcase
    end else begin
      op = (kind == K_READ) ? 2'b10 : 2'b01;
    end
    return {32'hFFFF_FFFF, st, op, phy, rg, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  AST_MDC_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q); // R2
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 read_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [HOLD_W-1:0]    hold_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 active_o,
  output logic                 mdio_o,
  output logic                 oe_o,
  output logic                 done_o,
  output logic                 ta_err_o,
  output logic [DWORD_W-1:0]   cap_o
);
  localparam int CW    = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL    = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] TA2    = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] DSTART = IDX_W'(TA_IDX + 2);

  logic                 active_q, read_q, pend_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [IDX_W-1:0]     idx_q;
  logic [HOLD_W-1:0]    hcnt_q, hold_eff;
  logic [DWORD_W-1:0]   cap_q;

  // hold cannot reach past the next rising edge
  assign hold_eff = (CW'(hold_i) > CW'(div_i)) ? HOLD_W'(div_i) : hold_i;

  assign active_o = active_q;
  assign done_o   = active_q && fall_i && (idx_q == LAST);
  assign oe_o     = active_q && !(read_q && idx_q >= REL);
  assign mdio_o   = oe_o & frame_q[LAST - idx_q];
  assign ta_err_o = active_q && read_q && rise_i && (idx_q == TA2) && mdio_i;
  assign cap_o    = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      read_q   <= 1'b0;
      pend_q   <= 1'b0;
      frame_q  <= '0;
      idx_q    <= '0;
      hcnt_q   <= '0;
      cap_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      read_q   <= read_i;
      frame_q  <= frame_i;
      idx_q    <= '0;
      pend_q   <= 1'b0;
    end else if (active_q) begin
      if (done_o) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
      end else if (fall_i) begin
        if (hold_eff == '0) idx_q <= idx_q + IDX_W'(1);
        else begin
          pend_q <= 1'b1;
          hcnt_q <= hold_eff;
        end
      end else if (pend_q) begin
        if (hcnt_q == HOLD_W'(1)) begin
          idx_q  <= idx_q + IDX_W'(1);
          pend_q <= 1'b0;
        end else begin
          hcnt_q <= hcnt_q - HOLD_W'(1);
        end
      end
      if (rise_i && read_q && idx_q >= DSTART) cap_q <= {cap_q[DWORD_W-2:0], mdio_i};
    end
  end

  AST_HOLD_BEFORE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> !pend_q); // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R10
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [3:0]           addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic                 active_i,
  input  logic                 done_i,
  input  logic                 ta_err_i,
  input  logic [DWORD_W-1:0]   cap_i,
  output logic                 start_o,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic                 read_o,
  output logic [DIV_W-1:0]     div_o,
  output logic [HOLD_W-1:0]    hold_o
);
  logic [DIV_W-1:0]   div_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               c45_q, err_q;
  logic [4:0]         phy_q, rg_q;
  logic [DWORD_W-1:0] data_q, addr_q;
  kind_e              kind_q, kind_n;
  logic [1:0]         sel;
  logic               wr, go_rd, go_wr, go_ad;
  logic               unused_bits;

  assign sel   = addr_i[3:2];
  assign wr    = req_i && we_i && !active_i;
  assign go_rd = wr && (sel == SEL_CTRL) && wdata_i[CTRL_RD_BIT];
  assign go_wr = wr && (sel == SEL_DATA);
  assign go_ad = wr && (sel == SEL_ADDR) && c45_q;
  assign unused_bits = ^{addr_i[1:0], wdata_i[31:16]};

  assign start_o = go_rd | go_wr | go_ad;
  assign read_o  = go_rd;
  assign div_o   = div_q;
  assign hold_o  = hold_q;
  assign kind_n  = go_rd ? K_READ : (go_wr ? K_WRITE : K_ADDR);

  always_comb begin
    if (go_rd)
      frame_o = build_frame(c45_q, K_READ, wdata_i[CTRL_PHY_LSB +: 5], wdata_i[4:0], '0);
    else
      frame_o = build_frame(c45_q, kind_n, phy_q, rg_q, wdata_i[DWORD_W-1:0]);
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CFG: begin
        rdata_o[BUSY_BIT]                    = active_i;
        rdata_o[CFG_ERR_BIT]                 = err_q;
        rdata_o[CFG_C45_BIT]                 = c45_q;
        rdata_o[CFG_HOLD_LSB +: HOLD_W]      = hold_q;
        rdata_o[DIV_W-1:0]                   = div_q;
      end
      SEL_CTRL: begin
        rdata_o[CTRL_PHY_LSB +: 5] = phy_q;
        rdata_o[4:0]               = rg_q;
      end
      SEL_DATA: begin
        rdata_o[BUSY_BIT]      = active_i && (kind_q != K_ADDR);
        rdata_o[DWORD_W-1:0]   = data_q;
      end
      default: rdata_o[DWORD_W-1:0] = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      hold_q <= '0;
      c45_q  <= 1'b0;
      err_q  <= 1'b0;
      phy_q  <= '0;
      rg_q   <= '0;
      data_q <= '0;
      addr_q <= '0;
      kind_q <= K_ADDR;
    end else begin
      if (wr) begin
        case (sel)
          SEL_CFG: begin
            div_q  <= wdata_i[DIV_W-1:0];
            hold_q <= wdata_i[CFG_HOLD_LSB +: HOLD_W];
            c45_q  <= wdata_i[CFG_C45_BIT];
          end
          SEL_CTRL: begin
            phy_q <= wdata_i[CTRL_PHY_LSB +: 5];
            rg_q  <= wdata_i[4:0];
          end
          SEL_DATA: data_q <= wdata_i[DWORD_W-1:0];
          default:  addr_q <= wdata_i[DWORD_W-1:0];
        endcase
      end
      if (start_o) kind_q <= kind_n;
      if (go_rd) err_q <= 1'b0;
      else if (ta_err_i) err_q <= 1'b1;
      if (done_i && kind_q == K_READ) data_q <= cap_i;
    end
  end

  AST_WRITE_DROPPED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && active_i && !done_i) |=> ($stable(data_q) && $stable(div_q) && $stable(phy_q) && $stable(addr_q))); // R10
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic                 start, rd, active, done, ta_err, rise, fall;
  logic [FRAME_LEN-1:0] frame;
  logic [DWORD_W-1:0]   cap;
  logic [DIV_W-1:0]     div;
  logic [HOLD_W-1:0]    hold;

  mdio_regs #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .active_i(active), .done_i(done), .ta_err_i(ta_err), .cap_i(cap),
    .start_o(start), .frame_o(frame), .read_o(rd), .div_o(div), .hold_o(hold)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(active), .div_i(div),
    .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_engine #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .frame_i(frame),
    .read_i(rd), .div_i(div), .hold_i(hold), .rise_i(rise), .fall_i(fall),
    .mdio_i(mdio_i), .active_o(active), .mdio_o(mdio_o), .oe_o(mdio_oe_o),
    .done_o(done), .ta_err_o(ta_err), .cap_o(cap)
  );

  AST_MDIO_STILL_MDC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R6
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0, cyc = 0;
  int m_L = 0, m_h = 1, m_he = 0;
  bit m_on = 0, m_read = 0, m_c45 = 0, ta_val = 0, bus_op = 0;
  logic [63:0] m_bits = '0;
  logic [15:0] phy_data = '0;
  int sh_div = 0, sh_hold = 0;
  logic [31:0] rv;

  mdio_master dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit c45, input int kind,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [1:0] op;
    if (c45) op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : 2'b11;
    else     op = (kind == 2) ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, phy, rg, 2'b10, d};
  endfunction

  function automatic int exp_idx(input int k);
    int r = 0;
    for (int j = 1; j < 64; j++) if (k >= 2*j*m_h + m_he) r = j;
    return r;
  endfunction

  // per-clock reference model and PHY responder
  always @(negedge clk) begin : model
    int k, idx;
    bit act, e_mdc, e_oe;
    if (rst_ni) begin
      k   = cyc - m_L;
      act = m_on && k >= 0 && k < 128*m_h;
      idx = act ? exp_idx(k) : 0;
      e_mdc = act && k >= m_h && (((k - m_h) / m_h) % 2 == 0);
      e_oe  = act && !(m_read && idx >= 46);
      chk("R2 mdc", mdc, e_mdc);
      chk(m_read ? "R7 oe" : "R3 oe", mdio_oe, e_oe);
      if (e_oe) chk(m_c45 ? "R4 mdio" : "R3 mdio", mdio_o, m_bits[63-idx]);
      if (!bus_op) chk("R9 busy", rdata[31], act);
      if (act && m_read && idx >= 47) mdio_i = (idx == 47) ? ta_val : phy_data[15-(idx-48)];
      else mdio_i = 1'b1;
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d,
      input bit launch, input bit is_rd, input logic [63:0] bits);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; bus_op = 1;
    if (launch) begin
      m_h = sh_div + 1; m_he = (sh_hold > sh_div) ? sh_div : sh_hold;
      m_read = is_rd; m_bits = bits; m_L = cyc + 1; m_on = 1;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = '0;
    @(negedge clk);
    bus_op = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; bus_op = 1;
    #1 d = rdata;
    @(negedge clk);
    addr = '0;
    @(negedge clk);
    bus_op = 0;
  endtask

  task automatic set_cfg(input int dv, input int hd, input bit c45);
    sh_div = dv; sh_hold = hd; m_c45 = c45;
    bus_write(4'h0, 32'(dv) | (32'(hd) << 8) | (32'(c45) << 12), 0, 0, '0);
  endtask

  task automatic wait_frame();
    repeat (128*m_h + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > WD_LIMIT) begin
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 mdc", mdc, 0);
    chk("R1 oe", mdio_oe, 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(4'(a*4), rv);
      chk("R1 reg", rv, 0);
    end

    // Clause 22 write, div 1, hold 0
    set_cfg(1, 0, 0);
    bus_read(4'h0, rv); chk("R5 cfg", rv, 32'h1);
    bus_write(4'h4, 32'h227, 0, 0, '0);
    repeat (3) @(negedge clk);
    bus_read(4'h0, rv); chk("R5 ctrl no frame", rv[31], 0);
    bus_read(4'h4, rv); chk("R5 ctrl", rv, 32'h227);
    bus_write(4'h8, 32'hA5C3, 1, 0, exp_frame(0, 1, 5'h11, 5'h07, 16'hA5C3));
    bus_read(4'h8, rv); chk("R9 data busy write", rv, 32'h8000_A5C3);
    wait_frame();
    bus_read(4'h8, rv); chk("R9 data idle", rv, 32'h0000_A5C3);

    // Clause 22 address write starts nothing
    bus_write(4'hC, 32'h55, 0, 0, '0);
    repeat (4) @(negedge clk);
    bus_read(4'h0, rv); chk("R5 c22 addr no frame", rv[31], 0);
    bus_read(4'hC, rv); chk("R5 addr", rv, 32'h55);

    // Clause 22 read, div 2, hold 2
    set_cfg(2, 2, 0);
    phy_data = 16'h1234; ta_val = 0;
    bus_write(4'h4, 32'h807F, 1, 1, exp_frame(0, 2, 5'h03, 5'h1F, 16'h0));
    wait_frame();
    bus_read(4'h8, rv); chk("R7 read data", rv, 32'h1234);
    bus_read(4'h0, rv); chk("R8 no err", rv[30], 0);
    bus_read(4'h4, rv); chk("R5 ctrl rd readback", rv, 32'h7F);

    // Clause 45, div 0, hold 3 clamped to 0
    set_cfg(0, 3, 1);
    bus_write(4'h4, 32'h41, 0, 0, '0);
    bus_write(4'hC, 32'hBEEF, 1, 0, exp_frame(1, 0, 5'h02, 5'h01, 16'hBEEF));
    bus_read(4'h8, rv); chk("R9 addr frame data busy", rv, 32'h1234);
    bus_read(4'h0, rv); chk("R9 addr frame cfg busy", rv, 32'h8000_1300);
    wait_frame();
    bus_write(4'h8, 32'h0F0F, 1, 0, exp_frame(1, 1, 5'h02, 5'h01, 16'h0F0F));
    bus_write(4'h8, 32'h1111, 0, 0, '0);   // R10 dropped
    bus_write(4'h0, 32'h5, 0, 0, '0);      // R10 dropped
    wait_frame();
    bus_read(4'h8, rv); chk("R10 data kept", rv, 32'h0F0F);
    bus_read(4'h0, rv); chk("R10 cfg kept", rv, 32'h1300);

    // Clause 45 read with bad turnaround
    phy_data = 16'hC0DE; ta_val = 1;
    bus_write(4'h4, 32'h8041, 1, 1, exp_frame(1, 2, 5'h02, 5'h01, 16'h0));
    wait_frame();
    bus_read(4'h0, rv); chk("R8 err set", rv[30], 1);
    bus_read(4'h8, rv); chk("R4 c45 read data", rv, 32'hC0DE);
    bus_write(4'h8, 32'h0001, 1, 0, exp_frame(1, 1, 5'h02, 5'h01, 16'h0001));
    wait_frame();
    bus_read(4'h0, rv); chk("R8 err sticky", rv[30], 1);
    phy_data = 16'h8001; ta_val = 0;
    bus_write(4'h4, 32'h8041, 1, 1, exp_frame(1, 2, 5'h02, 5'h01, 16'h0));
    wait_frame();
    bus_read(4'h0, rv); chk("R8 err cleared", rv[30], 0);
    bus_read(4'h8, rv); chk("R7 read data", rv, 32'h8001);

    // Clause 22 write, div 3, hold 2
    set_cfg(3, 2, 0);
    bus_write(4'h4, 32'h3FF, 0, 0, '0);
    bus_write(4'h8, 32'hFFFF, 1, 0, exp_frame(0, 1, 5'h1F, 5'h1F, 16'hFFFF));
    wait_frame();
    bus_read(4'h0, rv); chk("R6 idle after hold frame", rv, 32'h0203);
    finish_run();
  end
endmodule